// File: doc/BRIEF.md
# Dual-Mode Programmable Interval Timer

This block is a programmable interval timer that runs on the system clock. Software loads a terminal count one byte at a time, picks a mode, and then drives the timer with start, stop and reset strobes. In one-shot mode the single output falls once after the programmed number of clocks. In repeating mode the output is a square wave. When the count is odd, the high phase of that wave is one clock shorter than the low phase.

Writes and commands are locked while the timer runs. Count bytes and mode writes are dropped. Start is accepted only where the active mode allows it. The terminal count and the mode are captured when a start is accepted, so changes to the registers cannot disturb a run that is already in progress.

The timer output can take over a shared general-purpose pad. While it is routed there, the pad's own level and direction controls are ignored.

Top module: `interval_timer`

## Requirements
- R1: After system reset the timer output is HIGH, `running`, `timeout` and `pad_oe` are 0, `cfg_count` reads 0xFFFF and `cfg_mode` reads 0 (one-shot).
- R2: In one-shot mode (`cfg_mode`=0), after an accepted start the output stays HIGH for N clocks, then goes LOW and stays LOW. At that point `timeout` is set and `running` remains 1.
- R3: In one-shot mode, a start accepted before expiry reloads the count, so a full N-clock HIGH period begins from that start.
- R4: In one-shot mode, a start after expiry has no effect. A stop then drives the output HIGH and clears `running` and `timeout`.
- R5: In repeating mode (`cfg_mode`=1), the output is HIGH for P = floor(N/2) clocks, then LOW for Q = N - P clocks, and the cycle repeats until the timer is stopped.
- R6: In repeating mode, a start while running is ignored and does not disturb the waveform phase.
- R7: While running, writes to the count low byte (bits 7:0), the count high byte (bits 15:8) and the mode bit are dropped.
- R8: A reset command stops the timer, drives the output HIGH and clears `timeout`, but keeps the programmed count and mode.
- R9: A start is rejected while the programmed count is below 2. The timer stays idle with its output HIGH.
- R10: With `route_en`=1, one clock later `pad_oe` is 1 and `pad_out` follows the timer output with a one-clock lag. `gpio_lvl` and `gpio_oe` have no effect.
- R11: With `route_en`=0, `pad_out` and `pad_oe` follow `gpio_lvl` and `gpio_oe` with a one-clock lag.
- R12: A stop or reset command in the same cycle as a start wins, and the timer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_lo_we | input | 1 | Write strobe for count bits 7:0 |
| cnt_hi_we | input | 1 | Write strobe for count bits 15:8 |
| wr_data | input | 8 | Byte written by the count strobes |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_in | input | 1 | Mode value: 0 one-shot, 1 repeating |
| cmd_start | input | 1 | Start command strobe |
| cmd_stop | input | 1 | Stop command strobe |
| cmd_reset | input | 1 | Timer reset command strobe |
| route_en | input | 1 | Route the timer output onto the pad |
| gpio_lvl | input | 1 | Normal pad level control |
| gpio_oe | input | 1 | Normal pad direction control (1 = output) |
| tmr_out | output | 1 | Timer output, idle HIGH |
| running | output | 1 | Timer has been started and not stopped |
| timeout | output | 1 | Sticky one-shot expiry flag |
| cfg_count | output | 16 | Programmed terminal count |
| cfg_mode | output | 1 | Programmed mode |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that command and write strobes are sampled synchronously and that reset is held for at least one edge. They also assume that a started count is at least 2. The design enforces that last point itself by refusing smaller counts, so the bounds on the down-counter rest on the captured value. The stimulus changes every input on the falling clock edge and uses only small counts, so that whole periods fit into short windows. It also asserts stop and start together on purpose, to exercise the priority rule rather than avoid it.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_REPEAT  = 1'b1
  } tmode_e;
endpackage

// File: rtl/itmr_cfg.sv
module itmr_cfg
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  locked,
  input  logic                  lo_we,
  input  logic                  hi_we,
  input  logic [CNT_W/2-1:0]    wr_data,
  input  logic                  mode_we,
  input  logic                  mode_in,
  output logic [CNT_W-1:0]      count_q,
  output tmode_e                mode_q
);
  localparam int BYTE_W = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '1;
      mode_q  <= MODE_ONESHOT;
    end else if (!locked) begin
      if (lo_we)   count_q[BYTE_W-1:0]     <= wr_data;
      if (hi_we)   count_q[CNT_W-1:BYTE_W] <= wr_data;
      if (mode_we) mode_q                  <= tmode_e'(mode_in);
    end
  end

  // R7: configuration frozen while the timer runs
  assert_count_locked_R7: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(count_q));
  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(mode_q));
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  tmode_e            mode,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_reset,
  output logic              out_q,
  output logic              run_q,
  output logic              to_q
);
  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] n_lat;
  tmode_e           mode_lat;
  logic [CNT_W-1:0] p_lat, q_lat;
  logic             halt;
  logic             start_ok;

  assign p_lat = n_lat >> 1;
  assign q_lat = n_lat - p_lat;
  assign halt  = cmd_stop || cmd_reset;

  always_comb begin
    start_ok = 1'b0;
    if (cmd_start) begin
      if (!run_q)
        start_ok = (count >= MIN_N);
      else
        start_ok = (mode_lat == MODE_ONESHOT) && !to_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      out_q    <= 1'b1;
      to_q     <= 1'b0;
      cnt_q    <= '0;
      n_lat    <= '0;
      mode_lat <= MODE_ONESHOT;
    end else if (halt) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
      to_q  <= 1'b0;
      cnt_q <= '0;
    end else if (start_ok) begin
      if (!run_q) begin
        run_q    <= 1'b1;
        out_q    <= 1'b1;
        to_q     <= 1'b0;
        n_lat    <= count;
        mode_lat <= mode;
        cnt_q    <= (mode == MODE_REPEAT) ? (count >> 1) : count;
      end else begin
        cnt_q <= n_lat;
      end
    end else if (run_q && !to_q) begin
      if (cnt_q == ONE) begin
        if (mode_lat == MODE_ONESHOT) begin
          out_q <= 1'b0;
          to_q  <= 1'b1;
          cnt_q <= '0;
        end else if (out_q) begin
          out_q <= 1'b0;
          cnt_q <= q_lat;
        end else begin
          out_q <= 1'b1;
          cnt_q <= p_lat;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  // R1: an idle timer always holds its output HIGH
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> out_q);
  // R2: expiry leaves the timer started with its output LOW
  assert_expired_low_R2: assert property (@(posedge clk) disable iff (rst)
    to_q |-> (!out_q && run_q));
  // R5: the repeating waveform never sets the expiry flag
  assert_repeat_no_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    (run_q && mode_lat == MODE_REPEAT) |-> !to_q);
  // R2: the down-counter never exceeds the captured count
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= n_lat));
  // R12: stop or reset always leaves the timer idle and HIGH
  assert_halt_wins_R12: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!run_q && out_q && !to_q));
  // R9: a count below 2 never starts the timer
  assert_small_rejected_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_q && count < MIN_N) |=> !run_q);
endmodule

// File: rtl/itmr_pinmux.sv
module itmr_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic route_en,
  input  logic tmr_out,
  input  logic gpio_lvl,
  input  logic gpio_oe,
  output logic pad_out,
  output logic pad_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else if (route_en) begin
      pad_out <= tmr_out;
      pad_oe  <= 1'b1;
    end else begin
      pad_out <= gpio_lvl;
      pad_oe  <= gpio_oe;
    end
  end

  // R10: routing forces the pad to drive the timer level
  assert_route_drive_R10: assert property (@(posedge clk) disable iff (rst)
    route_en |=> (pad_oe && pad_out == $past(tmr_out)));
  // R11: without routing the pad follows the normal controls
  assert_gpio_follow_R11: assert property (@(posedge clk) disable iff (rst)
    !route_en |=> (pad_oe == $past(gpio_oe) && pad_out == $past(gpio_lvl)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_lo_we,
  input  logic               cnt_hi_we,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               mode_we,
  input  logic               mode_in,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic               cmd_reset,
  input  logic               route_en,
  input  logic               gpio_lvl,
  input  logic               gpio_oe,
  output logic               tmr_out,
  output logic               running,
  output logic               timeout,
  output logic [CNT_W-1:0]   cfg_count,
  output logic               cfg_mode,
  output logic               pad_out,
  output logic               pad_oe
);
  tmode_e mode_q;

  itmr_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .locked  (running),
    .lo_we   (cnt_lo_we),
    .hi_we   (cnt_hi_we),
    .wr_data (wr_data),
    .mode_we (mode_we),
    .mode_in (mode_in),
    .count_q (cfg_count),
    .mode_q  (mode_q)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .count     (cfg_count),
    .mode      (mode_q),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .cmd_reset (cmd_reset),
    .out_q     (tmr_out),
    .run_q     (running),
    .to_q      (timeout)
  );

  itmr_pinmux u_pin (
    .clk      (clk),
    .rst      (rst),
    .route_en (route_en),
    .tmr_out  (tmr_out),
    .gpio_lvl (gpio_lvl),
    .gpio_oe  (gpio_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign cfg_mode = mode_q;
endmodule

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_lo_we = 0, cnt_hi_we = 0, mode_we = 0, mode_in = 0;
  logic [7:0]  wr_data = '0;
  logic        cmd_start = 0, cmd_stop = 0, cmd_reset = 0;
  logic        route_en = 0, gpio_lvl = 0, gpio_oe = 0;
  logic        tmr_out, running, timeout, cfg_mode, pad_out, pad_oe;
  logic [15:0] cfg_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rst(rst), .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
    .wr_data(wr_data), .mode_we(mode_we), .mode_in(mode_in),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_reset(cmd_reset),
    .route_en(route_en), .gpio_lvl(gpio_lvl), .gpio_oe(gpio_oe),
    .tmr_out(tmr_out), .running(running), .timeout(timeout),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {mode, N}: mode 0 one-shot, 1 repeating
  localparam logic [16:0] VECS [8] = '{
    {1'b0, 16'd2}, {1'b0, 16'd3}, {1'b0, 16'd7}, {1'b0, 16'd12},
    {1'b1, 16'd2}, {1'b1, 16'd5}, {1'b1, 16'd8}, {1'b1, 16'd11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [15:0] n, input logic m);
    @(negedge clk); cnt_lo_we = 1; wr_data = n[7:0];
    @(negedge clk); cnt_lo_we = 0; cnt_hi_we = 1; wr_data = n[15:8];
    @(negedge clk); cnt_hi_we = 0; mode_we = 1; mode_in = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic pulse_start; cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
  task automatic pulse_stop;  cmd_stop  = 1; @(negedge clk); cmd_stop  = 0; endtask
  task automatic pulse_reset; cmd_reset = 1; @(negedge clk); cmd_reset = 0; endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (tmr_out === lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 out", tmr_out, 1);
    check("R1 running", running, 0);
    check("R1 timeout", timeout, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 count", cfg_count, 16'hFFFF);
    check("R1 mode", cfg_mode, 0);

    // table walk: R2 and R5
    foreach (VECS[i]) begin
      logic        m;
      logic [15:0] n;
      m = VECS[i][16];
      n = VECS[i][15:0];
      prog(n, m);
      @(negedge clk);
      pulse_start();
      if (!m) begin
        run_len(1'b1, len); check("R2 high length", len, n);
        check("R2 timeout", timeout, 1);
        check("R2 running", running, 1);
        repeat (3) @(negedge clk);
        check("R2 stays low", tmr_out, 0);
      end else begin
        run_len(1'b1, len); check("R5 high P", len, n / 2);
        run_len(1'b0, len); check("R5 low Q", len, n - n / 2);
        run_len(1'b1, len); check("R5 high P again", len, n / 2);
        run_len(1'b0, len); check("R5 low Q again", len, n - n / 2);
        check("R5 no timeout", timeout, 0);
      end
      pulse_stop();
    end

    // R3 restart before expiry
    prog(16'd10, 1'b0);
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();
    run_len(1'b1, len); check("R3 restart full period", len, 10);

    // R4 start after expiry ignored, then stop
    pulse_start();
    repeat (3) @(negedge clk);
    check("R4 out stays low", tmr_out, 0);
    check("R4 timeout kept", timeout, 1);
    pulse_stop();
    check("R4 stop out high", tmr_out, 1);
    check("R4 stop running", running, 0);
    check("R4 stop timeout", timeout, 0);

    // R6 repeat start while running ignored
    prog(16'd6, 1'b1);
    pulse_start();
    pulse_start();
    run_len(1'b1, len); check("R6 remaining high", len, 2);
    run_len(1'b0, len); check("R6 low", len, 3);
    pulse_stop();

    // R7 writes dropped while running
    prog(16'd40, 1'b0);
    pulse_start();
    cnt_lo_we = 1; wr_data = 8'h55; @(negedge clk); cnt_lo_we = 0;
    cnt_hi_we = 1; wr_data = 8'hAA; @(negedge clk); cnt_hi_we = 0;
    mode_we = 1; mode_in = 1; @(negedge clk); mode_we = 0;
    check("R7 count locked", cfg_count, 16'd40);
    check("R7 mode locked", cfg_mode, 0);
    pulse_stop();

    // R8 reset command keeps config
    prog(16'h0123, 1'b1);
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_reset();
    check("R8 running", running, 0);
    check("R8 out", tmr_out, 1);
    check("R8 count kept", cfg_count, 16'h0123);
    check("R8 mode kept", cfg_mode, 1);

    // R9 small counts rejected
    prog(16'd1, 1'b0);
    pulse_start();
    check("R9 N=1 rejected", running, 0);
    prog(16'd0, 1'b1);
    pulse_start();
    check("R9 N=0 rejected", running, 0);
    check("R9 out high", tmr_out, 1);

    // R12 stop with start in same cycle
    prog(16'd5, 1'b0);
    cmd_start = 1; cmd_stop = 1; @(negedge clk); cmd_start = 0; cmd_stop = 0;
    check("R12 stop beats start", running, 0);
    cmd_start = 1; cmd_reset = 1; @(negedge clk); cmd_start = 0; cmd_reset = 0;
    check("R12 reset beats start", running, 0);

    // R11 pad follows gpio controls
    route_en = 0; gpio_lvl = 1; gpio_oe = 1;
    @(negedge clk);
    check("R11 pad_oe", pad_oe, 1);
    check("R11 pad_out", pad_out, 1);
    gpio_lvl = 0;
    @(negedge clk);
    check("R11 pad_out low", pad_out, 0);

    // R10 routing overrides gpio
    route_en = 1; gpio_lvl = 0; gpio_oe = 0;
    @(negedge clk);
    check("R10 pad_oe forced", pad_oe, 1);
    check("R10 pad_out idle high", pad_out, 1);
    prog(16'd3, 1'b0);
    pulse_start();
    run_len(1'b1, len);
    @(negedge clk);
    check("R10 pad follows low", pad_out, 0);
    pulse_stop();
    @(negedge clk);
    check("R10 pad follows stop", pad_out, 1);

    // R1 system reset returns pad to input
    rst = 1; @(negedge clk); rst = 0; route_en = 0; gpio_oe = 0;
    check("R1 pad_oe after reset", pad_oe, 0);
    check("R1 count after reset", cfg_count, 16'hFFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule